// File: doc/BRIEF.md
# Serial receiver with multiprocessor address filtering

This block is the receive half of a four-mode asynchronous serial port in the classic 8-bit controller style. It watches a serial input and is paced by a 16x oversampling tick that comes from outside. From each frame it recovers eight data bits and, in the 9-bit modes, a ninth bit. It then raises a receive flag that software clears.

In the 9-bit modes a multiprocessor filter can be enabled. The filter treats frames whose ninth bit is 1 as addresses. The receive flag is raised only when such an address matches either a masked "given" address or a "broadcast" address, both of which are formed from an 8-bit own address and an 8-bit mask. When the stop bit is sampled low, a sticky framing-error flag is set. That flag can be read through a control-bit output which it shares with the upper mode bit.

Top module: `uart_rxa`

## Requirements
- R1: After a synchronous reset, rx_flag, fe_flag, rx_data and rx_bit9 are all 0.
- R2: mode = {upper, lower} selects the frame format. Mode 1 (01) is start bit, 8 data bits and stop bit. Modes 2 (10) and 3 (11) are start bit, 8 data bits, a ninth bit and stop bit. In mode 0 (00), or while rx_en is 0, no new frame is started.
- R3: Data bits arrive least significant first. Each bit lasts 16 ticks. The tick on which the idle receiver first sees rx_in low is phase 0. Each bit's value is the majority of rx_in at phases 7, 8 and 9 of that bit.
- R4: If the start bit votes high, the receiver returns to idle without loading anything. It can then start on the next low level it sees.
- R5: When a frame is accepted, rx_data takes the 8 data bits and rx_flag becomes 1. rx_bit9 takes the ninth bit in modes 2 and 3, and the stop bit in mode 1. While rx_flag is 1, a completed frame loads nothing. rx_flag_clr clears rx_flag.
- R6: fe_flag is set when a stop bit votes low, whether or not the frame is accepted. It stays set until an fe_clr pulse. A set in the same cycle as a clear wins.
- R7: With mp_en = 1 in mode 2 or 3, a frame is accepted only if its ninth bit is 1 and its 8-bit value hits the given or the broadcast address. Frames with a ninth bit of 0 are dropped.
- R8: The value hits the given address when it equals own_addr in every bit where addr_mask is 1. It hits the broadcast address when it is 0 in every bit where (own_addr | addr_mask) is 0.
- R9: In mode 1, mp_en has no effect and every completed frame is accepted.
- R10: ctl_bit shows fe_flag when fe_sel is 1, and mode[1] when fe_sel is 0.
- R11: The outputs of a frame update on the clock edge of the tick at phase 9 of the stop bit. They are therefore visible after stop-bit tick 10 and not after stop-bit tick 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial data input, idle high |
| os_tick | input | 1 | One-cycle 16x oversample enable |
| mode | input | 2 | Frame mode select {upper, lower} |
| mp_en | input | 1 | Multiprocessor address filter enable |
| rx_en | input | 1 | Receive enable |
| fe_sel | input | 1 | Show fe_flag on ctl_bit instead of mode[1] |
| own_addr | input | 8 | Own station address |
| addr_mask | input | 8 | Address mask |
| rx_flag_clr | input | 1 | Clear pulse for rx_flag |
| fe_clr | input | 1 | Clear pulse for fe_flag |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit (modes 2, 3) or stop bit (mode 1) |
| rx_flag | output | 1 | Receive flag |
| fe_flag | output | 1 | Sticky framing-error flag |
| ctl_bit | output | 1 | Shared control bit position |

## Verification
Every result of a frame is due on the clock edge that carries the tick at stop-bit phase 9. That is 16 ticks per bit after the detecting tick, with no further pipeline register. The bench drives each bit for exactly 16 ticks, changing rx_in on the falling clock edge just after a tick. It samples the outputs on falling edges only: after stop-bit tick 9, where the flag must still be clear, and after tick 10, where it must be set. The scoreboard monitor compares a queued expectation on each rising edge of rx_flag. Frames that must be dropped are checked once the full stop bit has passed.

// File: rtl/uart_rxa_pkg.sv
package uart_rxa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
    } rx_word_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rxa_timing.sv
module uart_rxa_timing #(
    parameter int OVS = 16,
    parameter int MID = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic rx,
    output logic vote_stb,
    output logic vote_val,
    output logic bit_end
);
    import uart_rxa_pkg::*;

    localparam int CW = $clog2(OVS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] ph;
    logic [1:0]    smp;

    assign ph = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            smp <= '0;
        end else if (tick) begin
            cnt <= (ph == CW'(OVS)) ? '0 : ph;
            if (ph == CW'(MID - 1)) smp[0] <= rx;
            if (ph == CW'(MID))     smp[1] <= rx;
        end
    end

    assign vote_stb = run & tick & (ph == CW'(MID + 1));
    assign vote_val = maj3(smp[0], smp[1], rx);
    assign bit_end  = run & tick & (ph == CW'(OVS));

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vote_stb, bit_end})); // R3
    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0)); // R4

endmodule

// File: rtl/uart_rxa_addr_filter.sv
module uart_rxa_addr_filter #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] own,
    input  logic [AW-1:0] mask,
    output logic          hit
);
    logic [AW-1:0] bcast;
    logic          hit_given;
    logic          hit_bcast;

    assign bcast     = own | mask;
    assign hit_given = ((addr ^ own) & mask) == '0;
    assign hit_bcast = (addr & ~bcast) == '0;
    assign hit       = hit_given | hit_bcast;

endmodule

// File: rtl/uart_rxa.sv
module uart_rxa #(
    parameter int OVS   = 16,
    parameter int MID   = 8,
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_in,
    input  logic             os_tick,
    input  logic [1:0]       mode,
    input  logic             mp_en,
    input  logic             rx_en,
    input  logic             fe_sel,
    input  logic [DBITS-1:0] own_addr,
    input  logic [DBITS-1:0] addr_mask,
    input  logic             rx_flag_clr,
    input  logic             fe_clr,
    output logic [DBITS-1:0] rx_data,
    output logic             rx_bit9,
    output logic             rx_flag,
    output logic             fe_flag,
    output logic             ctl_bit
);
    import uart_rxa_pkg::*;

    localparam int NBW = $clog2(DBITS + 1);

    rx_state_e        state;
    logic [DBITS-1:0] shreg;
    logic [NBW-1:0]   nbits;
    logic             ninth;
    logic             run;
    logic             vote_stb;
    logic             vote_val;
    logic             bit_end;
    logic             addr_hit;
    logic             nine_mode;
    logic             filter_on;
    logic             accept;

    assign run       = (state != ST_IDLE);
    assign nine_mode = mode[1];
    assign filter_on = mp_en & nine_mode;

    uart_rxa_timing #(.OVS(OVS), .MID(MID)) u_timing (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (os_tick),
        .rx       (rx_in),
        .vote_stb (vote_stb),
        .vote_val (vote_val),
        .bit_end  (bit_end)
    );

    uart_rxa_addr_filter #(.AW(DBITS)) u_filter (
        .addr (shreg),
        .own  (own_addr),
        .mask (addr_mask),
        .hit  (addr_hit)
    );

    assign accept = !rx_flag && (!filter_on || (ninth && addr_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            nbits   <= '0;
            ninth   <= 1'b0;
            rx_data <= '0;
            rx_bit9 <= 1'b0;
            rx_flag <= 1'b0;
            fe_flag <= 1'b0;
        end else begin
            if (rx_flag_clr) rx_flag <= 1'b0;
            if (fe_clr)      fe_flag <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (os_tick && rx_en && (mode != 2'b00) && !rx_in) begin
                        state <= ST_START;
                        nbits <= '0;
                    end
                end
                ST_START: begin
                    if (vote_stb && vote_val) state <= ST_IDLE;
                    else if (bit_end)         state <= ST_DATA;
                end
                ST_DATA: begin
                    if (vote_stb) begin
                        shreg <= {vote_val, shreg[DBITS-1:1]};
                        nbits <= nbits + 1'b1;
                    end
                    if (bit_end && nbits == NBW'(DBITS))
                        state <= nine_mode ? ST_NINTH : ST_STOP;
                end
                ST_NINTH: begin
                    if (vote_stb) ninth <= vote_val;
                    if (bit_end)  state <= ST_STOP;
                end
                ST_STOP: begin
                    if (vote_stb) begin
                        state <= ST_IDLE;
                        if (!vote_val) fe_flag <= 1'b1;
                        if (accept) begin
                            rx_data <= shreg;
                            rx_bit9 <= nine_mode ? ninth : vote_val;
                            rx_flag <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ctl_bit = fe_sel ? fe_flag : mode[1];

    AST_HOLD_WHILE_FLAG: assert property (@(posedge clk) disable iff (rst)
        rx_flag && !rx_flag_clr |=> rx_flag && $stable(rx_data)); // R5
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (rst)
        fe_flag && !fe_clr |=> fe_flag); // R6
    AST_ADDR_NINTH: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag) && $past(mp_en && mode[1]) |-> rx_bit9); // R7
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE && (!rx_en || mode == 2'b00) |=> state == ST_IDLE); // R2
    AST_FLAG_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag) |-> $past(state) == ST_STOP); // R11

endmodule

// File: tb/sim_uart_rxa.sv
module sim_uart_rxa;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       mp_en = 1'b0;
    logic       rx_en = 1'b1;
    logic       fe_sel = 1'b0;
    logic [7:0] own_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       rx_flag_clr = 1'b0;
    logic       fe_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_flag;
    logic       fe_flag;
    logic       ctl_bit;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    logic flag_q = 1'b0;
    logic flag_t9, flag_t10;
    int tdiv = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        os_tick <= (tdiv == 3);
    end

    uart_rxa u0 (
        .clk(clk), .rst(rst), .rx_in(rx_in), .os_tick(os_tick), .mode(mode),
        .mp_en(mp_en), .rx_en(rx_en), .fe_sel(fe_sel), .own_addr(own_addr),
        .addr_mask(addr_mask), .rx_flag_clr(rx_flag_clr), .fe_clr(fe_clr),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag),
        .fe_flag(fe_flag), .ctl_bit(ctl_bit)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // scoreboard monitor: pops on each rising edge of the receive flag
    always @(negedge clk) begin
        if (!rst && rx_flag && !flag_q) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected flag", 16'd1, 16'd0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check("R5 R3 scoreboard word", {7'd0, rx_data, rx_bit9}, {7'd0, e});
            end
        end
        flag_q = rx_flag;
    end

    task automatic wait_tick();
        do @(posedge clk); while (!os_tick);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) wait_tick();
    endtask

    task automatic send_frame(input logic [7:0] d, input logic nine,
                              input logic b9, input logic stopv);
        rx_in = 1'b1;
        wait_ticks(24);
        rx_in = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            wait_ticks(16);
        end
        if (nine) begin
            rx_in = b9;
            wait_ticks(16);
        end
        rx_in = stopv;
        wait_ticks(9);
        flag_t9 = rx_flag;
        wait_ticks(1);
        flag_t10 = rx_flag;
        wait_ticks(6);
        rx_in = 1'b1;
        wait_ticks(24);
    endtask

    task automatic clr_flag();
        @(negedge clk) rx_flag_clr = 1'b1;
        @(negedge clk) rx_flag_clr = 1'b0;
    endtask

    function automatic logic bench_hit(input logic [7:0] a, input logic [7:0] own,
                                       input logic [7:0] msk);
        logic g, b;
        g = 1'b1;
        b = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (msk[i] && a[i] != own[i]) g = 1'b0;
            if (!(own[i] | msk[i]) && a[i]) b = 1'b0;
        end
        return g | b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rx_flag", {15'd0, rx_flag}, 16'd0);
        check("R1 fe_flag", {15'd0, fe_flag}, 16'd0);
        check("R1 rx_data/bit9", {7'd0, rx_data, rx_bit9}, 16'd0);

        // R2 R3 R11 mode 1 byte, bit9 = stop bit
        exp_q.push_back({8'hA5, 1'b1});
        send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
        check("R11 flag before stop tick 10", {15'd0, flag_t9}, 16'd0);
        check("R11 flag after stop tick 10", {15'd0, flag_t10}, 16'd1);

        // R5 frame while flag set is not loaded
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        check("R5 data held while flag set", {8'd0, rx_data}, 16'h00A5);
        clr_flag();
        @(negedge clk);
        check("R5 flag cleared", {15'd0, rx_flag}, 16'd0);

        // R4 false start followed by a good frame
        rx_in = 1'b0;
        wait_ticks(4);
        rx_in = 1'b1;
        wait_ticks(30);
        check("R4 false start no flag", {15'd0, rx_flag}, 16'd0);
        exp_q.push_back({8'h11, 1'b1});
        send_frame(8'h11, 1'b0, 1'b0, 1'b1);
        clr_flag();

        // R6 R10 framing error, sticky, shared bit
        exp_q.push_back({8'h6E, 1'b0});
        send_frame(8'h6E, 1'b0, 1'b0, 1'b0);
        clr_flag();
        check("R6 fe set on low stop", {15'd0, fe_flag}, 16'd1);
        fe_sel = 1'b1;
        @(negedge clk);
        check("R10 ctl shows fe", {15'd0, ctl_bit}, 16'd1);
        fe_sel = 1'b0;
        @(negedge clk);
        check("R10 ctl shows mode[1]", {15'd0, ctl_bit}, 16'd0);
        exp_q.push_back({8'h22, 1'b1});
        send_frame(8'h22, 1'b0, 1'b0, 1'b1);
        clr_flag();
        check("R6 fe sticky", {15'd0, fe_flag}, 16'd1);
        @(negedge clk) fe_clr = 1'b1;
        @(negedge clk) fe_clr = 1'b0;
        check("R6 fe cleared", {15'd0, fe_flag}, 16'd0);

        // R2 mode 3 without filter, ninth bit 0
        mode = 2'b11;
        @(negedge clk);
        check("R10 ctl mode[1] high", {15'd0, ctl_bit}, 16'd1);
        exp_q.push_back({8'h5A, 1'b0});
        send_frame(8'h5A, 1'b1, 1'b0, 1'b1);
        clr_flag();

        // R7 R8 filter in mode 2
        mode = 2'b10;
        mp_en = 1'b1;
        own_addr = 8'h34;
        addr_mask = 8'hF0;
        foreach (exp_q[i]) ;
        begin
            logic [7:0] addrs[4];
            logic       b9s[4];
            addrs = '{8'h3F, 8'h5B, 8'h84, 8'h34};
            b9s   = '{1'b1, 1'b1, 1'b1, 1'b0};
            for (int k = 0; k < 4; k++) begin
                logic acc;
                acc = b9s[k] && bench_hit(addrs[k], own_addr, addr_mask);
                if (acc) exp_q.push_back({addrs[k], 1'b1});
                send_frame(addrs[k], 1'b1, b9s[k], 1'b1);
                check(acc ? "R8 address hit flag" : "R7 dropped frame flag",
                      {15'd0, rx_flag}, {15'd0, acc});
                clr_flag();
            end
        end

        // R9 mp_en ignored in mode 1
        mode = 2'b01;
        exp_q.push_back({8'h77, 1'b1});
        send_frame(8'h77, 1'b0, 1'b0, 1'b1);
        check("R9 mode1 accepts with mp_en", {15'd0, rx_flag}, 16'd1);
        clr_flag();
        mp_en = 1'b0;

        // R2 mode 0 and receiver disabled start nothing
        mode = 2'b00;
        send_frame(8'h00, 1'b0, 1'b0, 1'b1);
        check("R2 mode 0 no flag", {15'd0, rx_flag}, 16'd0);
        mode = 2'b01;
        rx_en = 1'b0;
        send_frame(8'h0F, 1'b0, 1'b0, 1'b1);
        check("R2 rx_en off no flag", {15'd0, rx_flag}, 16'd0);
        check("R2 data unchanged", {8'd0, rx_data}, 16'h0077);

        check("R5 scoreboard drained", exp_q.size(), 16'd0);
        finish_run();
    end

endmodule